// File: doc/BRIEF.md
# Two-Row Pipelined Sum-of-Absolute-Differences Unit

This unit measures how far a predicted picture block is from the original one by summing the absolute sample differences. On each valid beat it receives two rows of four 8-bit samples from the predicted block and the same two rows from the original block. It passes them through two registered stages. The first stage forms the eight absolute differences. The second stage reduces them with an adder tree and folds the result into a running sum.

A 2-bit mode, sampled at the start of each block, selects one of two behaviours. In the per-4×4 behaviour the unit emits one distortion value for every two beats, which is one 4×4 block. In the accumulate behaviour it keeps a single running total across a whole 8×8 block (8 beats) or a whole 16×16 block (32 beats) and emits only that total. A mode-decision stage downstream compares these values across candidate predictions. A start flag on the input marks a new block. The flag clears the running sum on the same beat it arrives, so consecutive blocks need no gap between them.

Top module: `sad_pair_unit`

## Requirements
- R1: While `rst` is high, and after it falls until the first result, `out_valid` is 0 and `out_sad` is 0.
- R2: Lane i (i = 0..7) of `pred_pix` and `orig_pix` occupies bits [8i+7:8i]. Lanes 0–3 are one row and lanes 4–7 are the next row. Each lane contributes |pred − orig| as an unsigned magnitude, so a 4×4 block with pred 255 and orig 0 gives 4080, and the reverse order gives 4080 as well.
- R3: With `in_mode` = 2'b00 or 2'b11 at block start, a block is two beats. `out_valid` rises at the clock edge that follows the edge capturing the block's second beat.
- R4: In per-4×4 mode, back-to-back beats yield one result every two cycles, with no idle cycle between blocks.
- R5: With `in_mode` = 2'b01 at block start, a block is 8 beats (8×8). Exactly one result, the sum over all 8 beats, appears one edge after the last beat.
- R6: With `in_mode` = 2'b10 at block start, a block is 32 beats (16×16). One total appears one edge after the last beat, and the full-scale value 65280 is represented without wrap.
- R7: A valid beat with `in_first` = 1 starts a new block on that beat and discards any partial sum. An unfinished block that is cut off this way produces no result.
- R8: `in_mode` is sampled only on the first beat of a block. Changes on later beats of the same block have no effect.
- R9: Cycles with `in_valid` = 0 are ignored whatever `in_first`, `in_mode` and the sample buses carry. Gaps between the beats of a block leave its result unchanged, and the result appears one edge after the last valid beat.
- R10: `out_valid` is high for exactly one cycle per result, and `out_sad` holds its value until the next result.
- R11: After a block's last beat, the next valid beat starts a new block even without `in_first`, and its mode is sampled on that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat qualifier for the sample buses |
| in_first | input | 1 | Marks the first beat of a block |
| in_mode | input | 2 | 00/11 per-4×4, 01 accumulate 8×8, 10 accumulate 16×16 |
| pred_pix | input | 64 | Eight predicted samples, two rows of four |
| orig_pix | input | 64 | Eight original samples, same layout |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_sad | output | 16 | Distortion value, held between strobes |

## Verification
A corrupted beat counter shows up as a result strobe at the wrong cycle. Depending on the fault, it comes too early, too late or not at all, and it becomes visible one edge after the beat where the framing went wrong. A running sum that is not cleared, or is cleared late, leaks one block's distortion into the next result, so a zero-distortion block placed right after a full-scale block exposes it within two cycles. A mode latched on the wrong beat changes the block length, so the strobe spacing shows the fault at the very next expected result.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic [1:0] {
    SAD_MODE_EMIT     = 2'b00,
    SAD_MODE_ACC_C    = 2'b01,
    SAD_MODE_ACC_L    = 2'b10,
    SAD_MODE_EMIT_ALT = 2'b11
  } sad_mode_e;

  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } sad_tag_t;

endpackage

// File: rtl/sad_frame_ctl.sv
module sad_frame_ctl
  import sad_pkg::*;
#(
  parameter int BEATS_EMIT = 2,
  parameter int BEATS_C    = 8,
  parameter int BEATS_L    = 32,
  localparam int CNT_W     = (BEATS_L > 2) ? $clog2(BEATS_L) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_first,
  input  logic [1:0] in_mode,
  output logic       blk_first,
  output logic       blk_last
);

  localparam logic [CNT_W-1:0] END_E = CNT_W'(BEATS_EMIT - 1);
  localparam logic [CNT_W-1:0] END_C = CNT_W'(BEATS_C - 1);
  localparam logic [CNT_W-1:0] END_L = CNT_W'(BEATS_L - 1);

  logic [CNT_W-1:0] cnt_q;
  sad_mode_e        mode_q;
  sad_mode_e        eff_mode;
  logic             start;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] end_pos;

  always_comb begin
    start    = in_first || (cnt_q == '0);
    eff_mode = start ? sad_mode_e'(in_mode) : mode_q;
    pos      = start ? '0 : cnt_q;
    unique case (eff_mode)
      SAD_MODE_ACC_C: end_pos = END_C;
      SAD_MODE_ACC_L: end_pos = END_L;
      default:        end_pos = END_E;
    endcase
    blk_first = start;
    blk_last  = (pos == end_pos);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mode_q <= SAD_MODE_EMIT;
    end else if (in_valid) begin
      mode_q <= eff_mode;
      cnt_q  <= blk_last ? '0 : pos + 1'b1;
    end
  end

endmodule

// File: rtl/sad_absdiff_stage.sv
module sad_absdiff_stage
  import sad_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int LANES    = 8,
  localparam int BUS_W   = SAMPLE_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             blk_first,
  input  logic             blk_last,
  input  logic [BUS_W-1:0] pred_pix,
  input  logic [BUS_W-1:0] orig_pix,
  output logic [BUS_W-1:0] ad_q,
  output sad_tag_t         tag_q
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SAMPLE_W-1:0] p, o, d;
    assign p = pred_pix[g*SAMPLE_W +: SAMPLE_W];
    assign o = orig_pix[g*SAMPLE_W +: SAMPLE_W];
    assign d = (p >= o) ? (p - o) : (o - p);

    always_ff @(posedge clk) begin
      if (rst) begin
        ad_q[g*SAMPLE_W +: SAMPLE_W] <= '0;
      end else if (in_valid) begin
        ad_q[g*SAMPLE_W +: SAMPLE_W] <= d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else begin
      tag_q.vld   <= in_valid;
      tag_q.first <= in_valid & blk_first;
      tag_q.last  <= in_valid & blk_last;
    end
  end

endmodule

// File: rtl/sad_tree_acc.sv
module sad_tree_acc
  import sad_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int LANES    = 8,
  parameter int ACC_W    = 16,
  localparam int BUS_W   = SAMPLE_W * LANES,
  localparam int TREE_W  = SAMPLE_W + $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] ad_q,
  input  sad_tag_t         tag_q,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_sad
);

  logic [TREE_W-1:0] tree_sum;
  logic [ACC_W-1:0]  run_q;
  logic [ACC_W-1:0]  nxt;

  always_comb begin
    tree_sum = '0;
    for (int i = 0; i < LANES; i++) begin
      tree_sum = tree_sum + TREE_W'(ad_q[i*SAMPLE_W +: SAMPLE_W]);
    end
    nxt = (tag_q.first ? '0 : run_q) + ACC_W'(tree_sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      out_sad   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= tag_q.vld & tag_q.last;
      if (tag_q.vld) begin
        run_q <= nxt;
        if (tag_q.last) out_sad <= nxt;
      end
    end
  end

endmodule

// File: rtl/sad_pair_unit.sv
module sad_pair_unit
  import sad_pkg::*;
#(
  parameter int SAMPLE_W      = 8,
  parameter int ROW_LEN       = 4,
  parameter int ROWS_PER_BEAT = 2,
  parameter int CHROMA_DIM    = 8,
  parameter int LUMA_DIM      = 16,
  localparam int LANES        = ROW_LEN * ROWS_PER_BEAT,
  localparam int BUS_W        = SAMPLE_W * LANES,
  localparam int ACC_W        = SAMPLE_W + $clog2(LUMA_DIM * LUMA_DIM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic [1:0]       in_mode,
  input  logic [BUS_W-1:0] pred_pix,
  input  logic [BUS_W-1:0] orig_pix,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_sad
);

  localparam int BEATS_EMIT = (ROW_LEN * ROW_LEN) / LANES;
  localparam int BEATS_C    = (CHROMA_DIM * CHROMA_DIM) / LANES;
  localparam int BEATS_L    = (LUMA_DIM * LUMA_DIM) / LANES;

  logic             blk_first, blk_last;
  logic [BUS_W-1:0] ad_q;
  sad_tag_t         tag_q;

  sad_frame_ctl #(
    .BEATS_EMIT(BEATS_EMIT), .BEATS_C(BEATS_C), .BEATS_L(BEATS_L)
  ) ctl_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_mode(in_mode), .blk_first(blk_first), .blk_last(blk_last)
  );

  sad_absdiff_stage #(.SAMPLE_W(SAMPLE_W), .LANES(LANES)) s1_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .blk_first(blk_first),
    .blk_last(blk_last), .pred_pix(pred_pix), .orig_pix(orig_pix),
    .ad_q(ad_q), .tag_q(tag_q)
  );

  sad_tree_acc #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .ACC_W(ACC_W)) s2_i (
    .clk(clk), .rst(rst), .ad_q(ad_q), .tag_q(tag_q),
    .out_valid(out_valid), .out_sad(out_sad)
  );

endmodule

// File: rtl/sad_pair_unit_chk.sv
module sad_pair_unit_chk #(
  parameter int ACC_W     = 16,
  parameter int MAX_TOTAL = 65280
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_sad
);

  // R1: a reset cycle leaves no result strobe behind it
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !out_valid);

  // R10: strobe lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R10: value held between strobes
  a_r10_hold_value: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_sad));

  // R3: a result is preceded, through both stages, by an accepted beat
  a_r3_result_follows_beat: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  // R6: the total never exceeds full scale of a 16x16 block
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sad <= ACC_W'(MAX_TOTAL)));

endmodule

bind sad_pair_unit sad_pair_unit_chk #(
  .ACC_W(ACC_W),
  .MAX_TOTAL(((1 << SAMPLE_W) - 1) * LUMA_DIM * LUMA_DIM)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_sad(out_sad)
);

// File: tb/sad_pair_unit_tb.sv
`timescale 1ns/1ps
module sad_pair_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_first = 1'b0;
  logic [1:0]  in_mode = 2'b00;
  logic [63:0] pred_pix = '0;
  logic [63:0] orig_pix = '0;
  logic        out_valid;
  logic [15:0] out_sad;

  always #2.5 clk = ~clk;

  sad_pair_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_mode(in_mode), .pred_pix(pred_pix), .orig_pix(orig_pix),
    .out_valid(out_valid), .out_sad(out_sad)
  );

  int cyc = 0;
  int n_vec = 0, n_bad = 0;
  int n_got = 0;
  int got_sad [0:255];
  int got_cyc [0:255];
  int exp_run = 0;
  int last_cyc = 0;
  logic [31:0] rng = 32'h1234_5678;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && out_valid && n_got < 256) begin
      got_sad[n_got] = int'(out_sad);
      got_cyc[n_got] = cyc;
      n_got++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  // kind: 0 random, 1 pred 255/orig 0, 2 pred 0/orig 255, 3 equal samples
  task automatic drive_beat(input logic first, input logic [1:0] mode, input int kind);
    @(negedge clk);
    in_valid = 1'b1;
    in_first = first;
    in_mode  = mode;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] p, o;
      next_rand();
      case (kind)
        1: begin p = 8'd255; o = 8'd0; end
        2: begin p = 8'd0; o = 8'd255; end
        3: begin p = rng[7:0]; o = rng[7:0]; end
        default: begin p = rng[7:0]; o = rng[15:8]; end
      endcase
      pred_pix[i*8 +: 8] = p;
      orig_pix[i*8 +: 8] = o;
      exp_run += (p >= o) ? int'(p - o) : int'(o - p);
    end
    @(posedge clk);
    #1;
    last_cyc = cyc;
    in_valid = 1'b0;
    in_first = 1'b0;
  endtask

  task automatic idle_junk(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      next_rand();
      in_valid = 1'b0;
      in_first = 1'b1;
      in_mode  = rng[1:0];
      pred_pix = {rng, rng};
      orig_pix = {~rng, rng};
    end
    @(negedge clk);
    in_first = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(out_valid), 0);
    chk("R1 sad in reset", int'(out_sad), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", int'(out_valid), 0);
    chk("R1 sad after reset", int'(out_sad), 0);
    chk("R1 no strobes", n_got, 0);
  endtask

  task automatic t_emit_single();
    int b = n_got;
    exp_run = 0;
    drive_beat(1'b1, 2'b00, 0);
    drive_beat(1'b0, 2'b00, 0);
    settle();
    chk("R3 single count", n_got - b, 1);
    chk("R2 random 4x4 value", got_sad[b], exp_run);
    chk("R3 timing", got_cyc[b], last_cyc + 1);
    @(negedge clk);
    chk("R10 hold value", int'(out_sad), exp_run);
    chk("R10 valid low after", int'(out_valid), 0);
  endtask

  task automatic t_emit_stream();
    int b = n_got;
    int e [0:3];
    int lc0;
    int kinds [0:3] = '{1, 2, 3, 0};
    for (int k = 0; k < 4; k++) begin
      exp_run = 0;
      drive_beat(k == 0, 2'b00, kinds[k]);
      drive_beat(1'b0, 2'b00, kinds[k]);
      e[k] = exp_run;
      if (k == 0) lc0 = last_cyc;
    end
    settle();
    chk("R4 stream count", n_got - b, 4);
    chk("R2 full scale pred>orig", got_sad[b], 4080);
    chk("R2 full scale orig>pred", got_sad[b+1], 4080);
    chk("R7 cleared between blocks", got_sad[b+2], 0);
    chk("R4 fourth value", got_sad[b+3], e[3]);
    chk("R4 first timing", got_cyc[b], lc0 + 1);
    for (int k = 1; k < 4; k++) chk("R4 spacing", got_cyc[b+k] - got_cyc[b+k-1], 2);
  endtask

  task automatic t_alt_emit();
    int b = n_got;
    exp_run = 0;
    drive_beat(1'b1, 2'b11, 0);
    drive_beat(1'b0, 2'b11, 0);
    settle();
    chk("R3 mode 11 count", n_got - b, 1);
    chk("R3 mode 11 value", got_sad[b], exp_run);
  endtask

  task automatic t_acc8();
    int b = n_got;
    exp_run = 0;
    for (int k = 0; k < 8; k++) drive_beat(k == 0, 2'b01, 0);
    settle();
    chk("R5 8x8 count", n_got - b, 1);
    chk("R5 8x8 value", got_sad[b], exp_run);
    chk("R5 8x8 timing", got_cyc[b], last_cyc + 1);
  endtask

  task automatic t_acc16_max();
    int b = n_got;
    exp_run = 0;
    for (int k = 0; k < 32; k++) drive_beat(k == 0, 2'b10, 1);
    settle();
    chk("R6 16x16 count", n_got - b, 1);
    chk("R6 16x16 full scale", got_sad[b], 65280);
    chk("R6 16x16 timing", got_cyc[b], last_cyc + 1);
  endtask

  task automatic t_back2back_acc();
    int b = n_got;
    int e0, lc0;
    exp_run = 0;
    for (int k = 0; k < 8; k++) drive_beat(k == 0, 2'b01, 1);
    e0 = exp_run; lc0 = last_cyc;
    exp_run = 0;
    for (int k = 0; k < 8; k++) drive_beat(k == 0, 2'b01, 3);
    settle();
    chk("R7 b2b count", n_got - b, 2);
    chk("R7 b2b first", got_sad[b], e0);
    chk("R7 b2b second cleared", got_sad[b+1], 0);
    chk("R7 b2b spacing", got_cyc[b+1] - got_cyc[b], 8);
    chk("R7 b2b first timing", got_cyc[b], lc0 + 1);
  endtask

  task automatic t_abort();
    int b = n_got;
    exp_run = 0;
    for (int k = 0; k < 3; k++) drive_beat(k == 0, 2'b01, 1);
    exp_run = 0;
    for (int k = 0; k < 8; k++) drive_beat(k == 0, 2'b01, 0);
    settle();
    chk("R7 abort count", n_got - b, 1);
    chk("R7 abort value", got_sad[b], exp_run);
    chk("R7 abort timing", got_cyc[b], last_cyc + 1);
  endtask

  task automatic t_mode_change();
    int b = n_got;
    exp_run = 0;
    drive_beat(1'b1, 2'b01, 0);
    for (int k = 1; k < 8; k++) drive_beat(1'b0, (k % 2) ? 2'b00 : 2'b10, 0);
    settle();
    chk("R8 mode change count", n_got - b, 1);
    chk("R8 mode change value", got_sad[b], exp_run);
    chk("R8 mode change timing", got_cyc[b], last_cyc + 1);
  endtask

  task automatic t_stall();
    int b = n_got;
    exp_run = 0;
    drive_beat(1'b1, 2'b00, 0);
    idle_junk(3);
    chk("R9 no result during gap", n_got - b, 0);
    drive_beat(1'b0, 2'b00, 0);
    settle();
    chk("R9 stall count", n_got - b, 1);
    chk("R9 stall value", got_sad[b], exp_run);
    chk("R9 stall timing", got_cyc[b], last_cyc + 1);
  endtask

  task automatic t_implicit();
    int b = n_got;
    int e0;
    exp_run = 0;
    for (int k = 0; k < 32; k++) drive_beat(k == 0, 2'b10, 0);
    e0 = exp_run;
    exp_run = 0;
    drive_beat(1'b0, 2'b00, 2);
    drive_beat(1'b0, 2'b00, 2);
    settle();
    chk("R11 implicit count", n_got - b, 2);
    chk("R11 16x16 value", got_sad[b], e0);
    chk("R11 implicit 4x4 value", got_sad[b+1], 4080);
    chk("R11 implicit timing", got_cyc[b+1], last_cyc + 1);
  endtask

  initial begin
    t_reset();
    t_emit_single();
    t_emit_stream();
    t_alt_emit();
    t_acc8();
    t_acc16_max();
    t_back2back_acc();
    t_abort();
    t_mode_change();
    t_stall();
    t_implicit();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule